// File: doc/BRIEF.md
# Nibble-Bus Program Memory Slice

This block is one program store on a shared four-bit bus. The bus is time-shared across a fixed instruction cycle of eight phases: three address phases, two fetch phases and three execute phases. Every store on the bus takes in an 8-bit program address, which arrives as two nibbles in the first two phases. In the third phase the processor broadcasts a four-bit chip code. Only the store whose strapped identity equals that code answers. It drives the addressed byte back in the two fetch phases, upper nibble first.

A sync input marks the last execute phase, so the next clock edge starts a new cycle at its first phase. Each slice holds 256 bytes. After reset each byte has a computed value. A separate load port can overwrite any byte at any time. The bus is modelled as a separate input and output with an enable. The execute phases and the electrical tristate behaviour are outside this block.

Top module: `nbus_prog_rom`

## Requirements
- R1: While reset is held (active low) and after its release, bus_oe is 0. After reset, the byte stored at address i equals i XOR INIT_XOR (default 8'h5A).
- R2: The phases advance in the order A1, A2, A3, M1, M2, X1, X2, X3 and then wrap. The bus nibble present in A1 becomes address bits 3:0, and the nibble present in A2 becomes address bits 7:4.
- R3: The slice is selected for a cycle only when the nibble on the bus in phase A3 equals chip_id. When the nibble differs, bus_oe stays 0 for the whole cycle.
- R4: When the slice is selected, bus_out carries bits 7:4 of the addressed byte in phase M1 and bits 3:0 in phase M2.
- R5: bus_oe is 1 only in phases M1 and M2. It is 0 in A1, A2, A3, X1, X2 and X3.
- R6: When sync is 1 at a clock edge, the next phase is A1, whatever the current phase is. A sync in the middle of a cycle restarts the sequence.
- R7: A clock edge with ld_we equal to 1 writes ld_data into the byte at ld_addr. Later fetches of that address return the new value.
- R8: bus_out is 4'h0 whenever bus_oe is 0.
- R9: Selection is decided again in every cycle. A match in one cycle does not carry over to a following cycle whose A3 code differs from chip_id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one period per phase |
| rst_n | input | 1 | Synchronous reset, active low |
| sync | input | 1 | High during the last execute phase; the next phase is A1 |
| bus_in | input | 4 | Nibble currently on the shared bus |
| chip_id | input | 4 | Strapped identity code of this slice |
| ld_we | input | 1 | Load-port write strobe |
| ld_addr | input | 8 | Load-port byte address |
| ld_data | input | 8 | Load-port byte value |
| bus_out | output | 4 | Nibble this slice drives onto the bus |
| bus_oe | output | 1 | High when this slice drives the bus |

## Verification
The assertions assume that sync is high only in the intended X3 cycle or as a deliberate restart. They also assume that chip_id and the bus nibble are stable across the clock edge that ends each phase. The stimulus changes every input on the falling clock edge only. The bench aligns each cycle with a sync pulse before it starts a fetch. Its restart cases place sync in phases A2 and M1 and then run a normal cycle to show that the sequence recovered. Every load-port write happens between whole cycles, followed by a fresh sync, so a write never lands in the middle of a fetch.

// File: rtl/nbr_pkg.sv
// Shared definitions for the nibble-bus program memory slice.
// Assumes the eight phases are encoded in their bus order.
package nbr_pkg;
    typedef enum logic [2:0] {
        PH_A1 = 3'd0,
        PH_A2 = 3'd1,
        PH_A3 = 3'd2,
        PH_M1 = 3'd3,
        PH_M2 = 3'd4,
        PH_X1 = 3'd5,
        PH_X2 = 3'd6,
        PH_X3 = 3'd7
    } phase_e;
endpackage

// File: rtl/nbr_phase_seq.sv
// Phase sequencer: tracks the current phase of the eight-phase cycle.
// Assumes sync is sampled on the clock edge that ends the current phase.
// Reset parks the sequencer in X3, so the first cycle starts at A1.
module nbr_phase_seq
    import nbr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sync,
    output phase_e phase
);
    phase_e phase_q;

    // Step to the next phase, or restart at A1 when sync is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_X3;
        else if (sync)
            phase_q <= PH_A1;
        else
            phase_q <= phase_e'(3'(phase_q + 3'd1));
    end

    assign phase = phase_q;
endmodule

// File: rtl/nbr_addr_sel.sv
// Address and select capture: assembles the program address from the
// two address-phase nibbles and latches the chip-code match in A3.
// Assumes bus_in is stable across the clock edge that ends each phase.
module nbr_addr_sel
    import nbr_pkg::*;
#(
    parameter int NW = 4,
    localparam int AW = 2 * NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  logic [NW-1:0] bus_in,
    input  logic [NW-1:0] chip_id,
    output logic [AW-1:0] addr,
    output logic          sel
);
    logic [NW-1:0] lo_q;
    logic [NW-1:0] hi_q;
    logic          sel_q;

    // Capture the low nibble in A1 and the high nibble in A2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (phase == PH_A1) begin
            lo_q <= bus_in;
        end else if (phase == PH_A2) begin
            hi_q <= bus_in;
        end
    end

    // Clear the match at A1; decide it again from the code seen in A3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= 1'b0;
        else if (phase == PH_A1)
            sel_q <= 1'b0;
        else if (phase == PH_A3)
            sel_q <= (bus_in == chip_id);
    end

    assign addr = {hi_q, lo_q};
    assign sel  = sel_q;
endmodule

// File: rtl/nbr_store.sv
// Byte store: DEPTH bytes with a synchronous load port and an
// asynchronous read. Reset fills byte i with i XOR INIT_XOR.
module nbr_store #(
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter logic [DW-1:0] INIT_XOR = 8'h5A,
    localparam int         DEPTH    = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Load the computed contents on reset; otherwise accept load-port writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= DW'(i) ^ INIT_XOR;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Return the byte at the fetch address.
    assign rdata = mem[raddr];
endmodule

// File: rtl/nbr_checker.sv
// Property checker for nbus_prog_rom, bound to every instance.
// Assumes its inputs are stable across the rising clock edge.
module nbr_checker
    import nbr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sync,
    input logic [3:0] bus_in,
    input logic [3:0] chip_id,
    input logic       bus_oe,
    input logic [3:0] bus_out,
    input phase_e     phase,
    input logic [7:0] addr
);
    // R5
    oe_fetch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (phase == PH_M1 || phase == PH_M2));

    // R6
    sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (phase == PH_A1));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == 4'h0));

    // R2
    lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_A1) |=> (addr[3:0] == $past(bus_in)));

    // R3
    code_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> ($past(phase) == PH_A3 && $past(bus_in) == $past(chip_id)));

    // R4
    fetch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_M1 && bus_oe && !sync) |=> bus_oe);
endmodule

bind nbus_prog_rom nbr_checker u_nbr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync    (sync),
    .bus_in  (bus_in),
    .chip_id (chip_id),
    .bus_oe  (bus_oe),
    .bus_out (bus_out),
    .phase   (phase),
    .addr    (fetch_addr)
);

// File: rtl/nbus_prog_rom.sv
// Program memory slice on a shared nibble bus.
// Takes an 8-bit address in A1/A2 and compares the A3 code with chip_id.
// When selected, returns the addressed byte in M1 (high nibble) and
// M2 (low nibble). Assumes the phase clock runs one period per phase.
module nbus_prog_rom
    import nbr_pkg::*;
#(
    parameter int         NW       = 4,
    parameter logic [7:0] INIT_XOR = 8'h5A,
    localparam int        AW       = 2 * NW,
    localparam int        DW       = 2 * NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync,
    input  logic [NW-1:0] bus_in,
    input  logic [NW-1:0] chip_id,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic [NW-1:0] bus_out,
    output logic          bus_oe
);
    phase_e        phase;
    logic [AW-1:0] fetch_addr;
    logic          sel;
    logic [DW-1:0] fetch_byte;

    nbr_phase_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .sync  (sync),
        .phase (phase)
    );

    nbr_addr_sel #(.NW(NW)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .bus_in  (bus_in),
        .chip_id (chip_id),
        .addr    (fetch_addr),
        .sel     (sel)
    );

    nbr_store #(.AW(AW), .DW(DW), .INIT_XOR(INIT_XOR)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ld_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (fetch_addr),
        .rdata (fetch_byte)
    );

    // Drive the bus only in the fetch phases of a selected cycle, high nibble first.
    always_comb begin
        bus_oe  = sel && (phase == PH_M1 || phase == PH_M2);
        bus_out = '0;
        if (bus_oe)
            bus_out = (phase == PH_M1) ? fetch_byte[DW-1:NW] : fetch_byte[NW-1:0];
    end
endmodule

// File: tb/nbus_prog_rom_bench.sv
`timescale 1ns/1ps
module nbus_prog_rom_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync = 1'b0;
    logic [3:0] bus_in = 4'h0;
    logic [3:0] chip_id = 4'h9;
    logic       ld_we = 1'b0;
    logic [7:0] ld_addr = 8'h00;
    logic [7:0] ld_data = 8'h00;
    logic [3:0] bus_out;
    logic       bus_oe;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [256];

    always #2.5 clk = ~clk;

    nbus_prog_rom u_nbus_prog_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync    (sync),
        .bus_in  (bus_in),
        .chip_id (chip_id),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive sync in the current phase, so the next phase is A1.
    task automatic prime();
        @(negedge clk);
        sync = 1'b1;
        bus_in = 4'h0;
    endtask

    // One full cycle starting at A1; checks the bus_oe and bus_out pattern.
    task automatic fetch(input logic [7:0] addr, input logic [3:0] code, input string tag);
        logic hit;
        hit = (code == chip_id);
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            sync = (p == 7);
            case (p)
                0: bus_in = addr[3:0];
                1: bus_in = addr[7:4];
                2: bus_in = code;
                default: bus_in = 4'h0;
            endcase
            if (p == 3) begin
                chk({tag, " R4 M1 oe"}, {7'd0, bus_oe}, {7'd0, hit});
                chk({tag, " R4 M1 nibble"}, {4'h0, bus_out}, hit ? {4'h0, model[addr][7:4]} : 8'h00);
            end else if (p == 4) begin
                chk({tag, " R4 M2 oe"}, {7'd0, bus_oe}, {7'd0, hit});
                chk({tag, " R4 M2 nibble"}, {4'h0, bus_out}, hit ? {4'h0, model[addr][3:0]} : 8'h00);
            end else begin
                chk({tag, " R5 oe off"}, {7'd0, bus_oe}, 8'h00);
                chk({tag, " R8 idle zero"}, {4'h0, bus_out}, 8'h00);
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", {7'd0, bus_oe}, 8'h00);
        chk("R8 bus in reset", {4'h0, bus_out}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", {7'd0, bus_oe}, 8'h00);
        for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ 8'h5A;
        prime();
    endtask

    task automatic t_default_contents();
        fetch(8'h00, 4'h9, "R1 R2 addr00");
        fetch(8'hA5, 4'h9, "R1 R2 addrA5");
        fetch(8'h3C, 4'h9, "R2 addr3C");
        fetch(8'hFF, 4'h9, "R2 addrFF");
    endtask

    task automatic t_select();
        fetch(8'h12, 4'h9, "R3 match");
        fetch(8'h12, 4'h8, "R9 R3 mismatch after match");
        fetch(8'h12, 4'h1, "R3 mismatch");
        chip_id = 4'h1;
        fetch(8'h77, 4'h1, "R3 new strap");
        fetch(8'h77, 4'h9, "R3 old code");
        chip_id = 4'h9;
    endtask

    task automatic t_load();
        @(negedge clk);
        sync = 1'b0;
        ld_we = 1'b1; ld_addr = 8'h12; ld_data = 8'hC3; model[8'h12] = 8'hC3;
        @(negedge clk);
        ld_addr = 8'hF0; ld_data = 8'h0E; model[8'hF0] = 8'h0E;
        @(negedge clk);
        ld_we = 1'b0;
        prime();
        fetch(8'h12, 4'h9, "R7 loaded 12");
        fetch(8'hF0, 4'h9, "R7 loaded F0");
        fetch(8'h13, 4'h9, "R7 neighbour kept");
    endtask

    task automatic t_resync();
        // Restart from A2.
        @(negedge clk); sync = 1'b0; bus_in = 4'h4;
        @(negedge clk); sync = 1'b1;
        chk("R6 oe in A2", {7'd0, bus_oe}, 8'h00);
        fetch(8'h5B, 4'h9, "R6 after A2 sync");
        // Restart from M1 of a non-matching cycle.
        @(negedge clk); sync = 1'b0; bus_in = 4'h0;
        @(negedge clk);
        @(negedge clk); bus_in = 4'h0;
        @(negedge clk); sync = 1'b1;
        chk("R6 oe stray M1", {7'd0, bus_oe}, 8'h00);
        fetch(8'hC7, 4'h9, "R6 after M1 sync");
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog: actual=%h expected=%h", 1'b1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_default_contents();
        t_select();
        t_load();
        t_resync();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule